// File: doc/BRIEF.md
# Shifted-Address Load with Base Post-Increment

This execution unit runs one indexed load at a time for a family of load operations that advance their base register after the access. It receives the values of two 64-bit registers (a base and an index), the numbers of the base and target registers, a two-bit shift field, an access size code and a sign-extension flag. The memory address is the base value shifted left by one more than the shift field, with no displacement added. The unit raises a read request on a valid/ready memory port and waits for a single-cycle response. It then extends the right-aligned returned bytes to 64 bits.

When the response arrives, the unit presents two write-backs in the same cycle. One carries the loaded value for the target register. The other carries the unshifted base plus the index for the base register. Both come with a one-cycle done pulse. An operation whose base register number is zero, or equals the target register number, is rejected. The unit makes no memory request, pulses done with the illegal flag set and enables neither write-back.

The sequencer has four states. IDLE accepts an operation. ISSUE holds the memory request until it is taken. AWAIT waits for the response. REJECT reports an illegal operation. The transitions are:
- accept-legal: IDLE to ISSUE.
- accept-illegal: IDLE to REJECT.
- granted: ISSUE to AWAIT, when the request handshake completes.
- returned: AWAIT to IDLE, on the response cycle.
- reported: REJECT to IDLE, after one cycle.

Top module: `shifted_postinc_load`

## Requirements
- R1: The request address equals the captured base value shifted left by (shift field + 1), so by 1 to 4 bit positions; bits shifted past bit 63 are lost.
- R2: The request byte count is 1, 2, 4 or 8 for size codes 0, 1, 2 and 3. The request valid, address and byte count stay constant until the cycle in which ready is seen high.
- R3: The base write-back data equals the unshifted captured base plus the captured index, modulo 2^64. It is tagged with the base register number.
- R4: For size code 0 (byte), the result holds response bits 7:0 with bits 63:8 cleared, whatever the sign flag.
- R5: For size code 1 (halfword), the result holds response bits 15:0. Bits 63:16 are zero when the sign flag is 0 and copies of bit 15 when it is 1.
- R6: For size code 2 (word), the result holds response bits 31:0. Bits 63:32 are zero when the sign flag is 0 and copies of bit 31 when it is 1.
- R7: For size code 3 (doubleword), the result equals the 64-bit response, whatever the sign flag.
- R8: An operation whose base register number is 0, or equals the target register number, makes no memory request. In the cycle after acceptance, done and illegal are high and both write enables are low.
- R9: For a legal operation, done, the target write enable and the base write enable are high together only in the cycle in which the response valid is high in AWAIT. Illegal is low then, and the target write-back carries the target register number.
- R10: op_ready is high only in IDLE. The unit is back in IDLE in the cycle after any done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle and accepting |
| base_val | input | 64 | Base register value |
| index_val | input | 64 | Index register value |
| shift_sel | input | 2 | Shift field; address shift is value+1 |
| size_sel | input | 2 | Access size code (0=byte,1=half,2=word,3=double) |
| sign_ext | input | 1 | Sign-extend half and word loads |
| base_id | input | 5 | Base register number |
| tgt_id | input | 5 | Target register number |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 64 | Read address |
| mem_req_bytes | output | 4 | Bytes to read |
| mem_rsp_valid | input | 1 | Read data valid (one cycle) |
| mem_rsp_data | input | 64 | Read data, right-aligned |
| done | output | 1 | Operation complete pulse |
| illegal | output | 1 | Operation rejected (with done) |
| tgt_we | output | 1 | Target write enable |
| tgt_wid | output | 5 | Target register number |
| tgt_wdata | output | 64 | Extended load value |
| base_we | output | 1 | Base write enable |
| base_wid | output | 5 | Base register number |
| base_wdata | output | 64 | Post-incremented base |

## Verification
Two functions land in the same cycle here: the target write-back of the extended load and the base write-back of base plus index. Both fall in the cycle in which the memory response is consumed. The bench provokes this with random sizes, sign flags, shifts, grant stalls and response delays. In that response cycle it compares both write-back buses, their enables and their register numbers against values computed in the bench. It also confirms that neither enable appears in any other cycle, and that a rejected operation raises neither.

// File: rtl/spl_pkg.sv
package spl_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ISSUE  = 2'd1,
        ST_AWAIT  = 2'd2,
        ST_REJECT = 2'd3
    } seq_state_e;
endpackage

// File: rtl/spl_addr_scaler.sv
module spl_addr_scaler #(
    parameter int XLEN = 64,
    parameter int SHW  = 2
) (
    input  logic [XLEN-1:0] base_in,
    input  logic [SHW-1:0]  shift_in,
    output logic [XLEN-1:0] addr_out
);
    localparam int AMTW = SHW + 1;

    logic [AMTW-1:0] amount;

    always_comb begin
        amount   = {1'b0, shift_in} + AMTW'(1);
        addr_out = base_in << amount;
    end
endmodule

// File: rtl/spl_load_extend.sv
module spl_load_extend #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]                   raw,
    input  logic [$clog2($clog2(XLEN/8)+1)-1:0] size_code,
    input  logic                              sign_ext,
    output logic [XLEN-1:0]                   result
);
    localparam int NSIZE = $clog2(XLEN/8) + 1;

    logic [XLEN-1:0] cand [NSIZE];

    generate
        for (genvar k = 0; k < NSIZE; k++) begin : g_size
            localparam int W = 8 << k;
            if (W >= XLEN) begin : g_full
                assign cand[k] = raw;
            end else if (k == 0) begin : g_byte
                assign cand[k] = {{(XLEN-W){1'b0}}, raw[W-1:0]};
            end else begin : g_part
                assign cand[k] = sign_ext ? {{(XLEN-W){raw[W-1]}}, raw[W-1:0]}
                                          : {{(XLEN-W){1'b0}}, raw[W-1:0]};
            end
        end
    endgenerate

    always_comb begin
        result = cand[0];
        for (int i = 0; i < NSIZE; i++) begin
            if (int'(size_code) == i) result = cand[i];
        end
    end
endmodule

// File: rtl/spl_sequencer.sv
module spl_sequencer
    import spl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic op_valid,
    input  logic op_legal,
    input  logic req_ready,
    input  logic rsp_valid,
    output logic op_ready,
    output logic req_valid,
    output logic finish,
    output logic reject,
    output logic writeback
);
    seq_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (op_valid) state_nx = op_legal ? ST_ISSUE : ST_REJECT;
            end
            ST_ISSUE: begin
                if (req_ready) state_nx = ST_AWAIT;
            end
            ST_AWAIT: begin
                if (rsp_valid) state_nx = ST_IDLE;
            end
            ST_REJECT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        op_ready  = 1'b0;
        req_valid = 1'b0;
        finish    = 1'b0;
        reject    = 1'b0;
        writeback = 1'b0;
        unique case (state)
            ST_IDLE:  op_ready = 1'b1;
            ST_ISSUE: req_valid = 1'b1;
            ST_AWAIT: begin
                finish    = rsp_valid;
                writeback = rsp_valid;
            end
            ST_REJECT: begin
                finish = 1'b1;
                reject = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/shifted_postinc_load.sv
module shifted_postinc_load
    import spl_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int SHW  = 2,
    parameter int RIDW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    output logic            op_ready,
    input  logic [XLEN-1:0] base_val,
    input  logic [XLEN-1:0] index_val,
    input  logic [SHW-1:0]  shift_sel,
    input  logic [1:0]      size_sel,
    input  logic            sign_ext,
    input  logic [RIDW-1:0] base_id,
    input  logic [RIDW-1:0] tgt_id,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [XLEN-1:0] mem_req_addr,
    output logic [3:0]      mem_req_bytes,
    input  logic            mem_rsp_valid,
    input  logic [XLEN-1:0] mem_rsp_data,
    output logic            done,
    output logic            illegal,
    output logic            tgt_we,
    output logic [RIDW-1:0] tgt_wid,
    output logic [XLEN-1:0] tgt_wdata,
    output logic            base_we,
    output logic [RIDW-1:0] base_wid,
    output logic [XLEN-1:0] base_wdata
);
    logic [XLEN-1:0] base_q, index_q;
    logic [SHW-1:0]  shift_q;
    acc_size_e       size_q;
    logic            sign_q;
    logic [RIDW-1:0] base_id_q, tgt_id_q;
    logic            legal, accept, writeback;

    assign legal  = (base_id != '0) && (base_id != tgt_id);
    assign accept = op_valid && op_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q    <= '0;
            index_q   <= '0;
            shift_q   <= '0;
            size_q    <= SZ_BYTE;
            sign_q    <= 1'b0;
            base_id_q <= '0;
            tgt_id_q  <= '0;
        end else if (accept) begin
            base_q    <= base_val;
            index_q   <= index_val;
            shift_q   <= shift_sel;
            size_q    <= acc_size_e'(size_sel);
            sign_q    <= sign_ext;
            base_id_q <= base_id;
            tgt_id_q  <= tgt_id;
        end
    end

    spl_sequencer u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_legal  (legal),
        .req_ready (mem_req_ready),
        .rsp_valid (mem_rsp_valid),
        .op_ready  (op_ready),
        .req_valid (mem_req_valid),
        .finish    (done),
        .reject    (illegal),
        .writeback (writeback)
    );

    spl_addr_scaler #(.XLEN(XLEN), .SHW(SHW)) u_addr (
        .base_in  (base_q),
        .shift_in (shift_q),
        .addr_out (mem_req_addr)
    );

    spl_load_extend #(.XLEN(XLEN)) u_ext (
        .raw       (mem_rsp_data),
        .size_code (size_q),
        .sign_ext  (sign_q),
        .result    (tgt_wdata)
    );

    assign mem_req_bytes = 4'(1) << size_q;
    assign tgt_we        = writeback;
    assign base_we       = writeback;
    assign tgt_wid       = tgt_id_q;
    assign base_wid      = base_id_q;
    assign base_wdata    = base_q + index_q;
endmodule

// File: rtl/spl_checker.sv
module spl_checker #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_ready,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [XLEN-1:0] mem_req_addr,
    input logic [3:0]      mem_req_bytes,
    input logic            mem_rsp_valid,
    input logic            done,
    input logic            illegal,
    input logic            tgt_we,
    input logic            base_we
);
    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_bytes));

    assert_reject_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> done && !tgt_we && !base_we && !mem_req_valid);

    assert_wb_with_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_we |-> done && base_we && mem_rsp_valid && !illegal);

    assert_done_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> illegal || (tgt_we && base_we));

    assert_idle_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> op_ready && !done);

    assert_ready_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        op_ready |-> !mem_req_valid && !done);
endmodule

bind shifted_postinc_load spl_checker #(.XLEN(XLEN)) u_spl_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_ready      (op_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_req_bytes (mem_req_bytes),
    .mem_rsp_valid (mem_rsp_valid),
    .done          (done),
    .illegal       (illegal),
    .tgt_we        (tgt_we),
    .base_we       (base_we)
);

// File: tb/tb_shifted_postinc_load.sv
`timescale 1ns/1ps
module tb_shifted_postinc_load;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_ready;
    logic [63:0] base_val = '0, index_val = '0;
    logic [1:0]  shift_sel = '0, size_sel = '0;
    logic        sign_ext = 1'b0;
    logic [4:0]  base_id = '0, tgt_id = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr;
    logic [3:0]  mem_req_bytes;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        done, illegal, tgt_we, base_we;
    logic [4:0]  tgt_wid, base_wid;
    logic [63:0] tgt_wdata, base_wdata;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    shifted_postinc_load dut (.*);

    function automatic logic [63:0] exp_ext(logic [63:0] d, logic [1:0] sz, logic sg);
        case (sz)
            2'd0: return {56'd0, d[7:0]};
            2'd1: return sg ? {{48{d[15]}}, d[15:0]} : {48'd0, d[15:0]};
            2'd2: return sg ? {{32{d[31]}}, d[31:0]} : {32'd0, d[31:0]};
            default: return d;
        endcase
    endfunction

    function automatic string size_req(logic [1:0] sz);
        case (sz)
            2'd0: return "R4";
            2'd1: return "R5";
            2'd2: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(logic [63:0] b, logic [63:0] ix, logic [1:0] sh, logic [1:0] sz,
                          logic sg, logic [4:0] bid, logic [4:0] tid, logic [63:0] rdata);
        bit legal;
        logic [63:0] exp_addr;
        int stall;
        legal    = (bid != 0) && (bid != tid);
        exp_addr = b << (sh + 1);
        check(op_ready == 1'b1, "R10", {63'd0, op_ready}, 64'd1);
        base_val = b; index_val = ix; shift_sel = sh; size_sel = sz;
        sign_ext = sg; base_id = bid; tgt_id = tid; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        base_val = $urandom; index_val = $urandom; shift_sel = 2'($urandom);
        size_sel = 2'($urandom); sign_ext = 1'($urandom); base_id = 5'($urandom);
        if (!legal) begin
            check(done && illegal && !tgt_we && !base_we && !mem_req_valid, "R8",
                  {59'd0, done, illegal, tgt_we, base_we, mem_req_valid}, 64'h18);
            @(negedge clk);
            check(op_ready && !done, "R10", {62'd0, op_ready, done}, 64'd2);
            return;
        end
        check(!done && !op_ready, "R10", {62'd0, done, op_ready}, 64'd0);
        stall = $urandom_range(0, 3);
        for (int i = 0; i < stall; i++) begin
            check(mem_req_valid && mem_req_addr == exp_addr, "R2", mem_req_addr, exp_addr);
            @(negedge clk);
        end
        mem_req_ready = 1'b1;
        #1;
        check(mem_req_valid == 1'b1, "R2", {63'd0, mem_req_valid}, 64'd1);
        check(mem_req_addr == exp_addr, "R1", mem_req_addr, exp_addr);
        check(mem_req_bytes == (4'd1 << sz), "R2", {60'd0, mem_req_bytes}, {60'd0, 4'd1 << sz});
        @(negedge clk);
        mem_req_ready = 1'b0;
        stall = $urandom_range(0, 3);
        for (int i = 0; i < stall; i++) begin
            check(!done && !tgt_we && !base_we && !mem_req_valid, "R9",
                  {60'd0, done, tgt_we, base_we, mem_req_valid}, 64'd0);
            @(negedge clk);
        end
        mem_rsp_valid = 1'b1; mem_rsp_data = rdata;
        #1;
        check(done && tgt_we && base_we && !illegal && tgt_wid == tid, "R9",
              {56'd0, done, tgt_we, base_we, illegal, 4'd0}, {56'd0, 4'b1110, 4'd0});
        check(tgt_wdata == exp_ext(rdata, sz, sg), size_req(sz), tgt_wdata, exp_ext(rdata, sz, sg));
        check(base_wdata == b + ix && base_wid == bid, "R3", base_wdata, b + ix);
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_data = $urandom;
        #1;
        check(op_ready && !done && !tgt_we, "R10", {61'd0, op_ready, done, tgt_we}, 64'd4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(!mem_req_valid && !done && !tgt_we && !base_we, "R10",
              {60'd0, mem_req_valid, done, tgt_we, base_we}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // Directed corners: overflow of the shift, every size, sign flag on byte and double.
        run_op(64'hC000_0000_0000_0001, 64'd8, 2'd3, 2'd0, 1'b1, 5'd3, 5'd4, 64'hFFFF_FFFF_FFFF_FF80);
        run_op(64'h8000_0000_0000_0003, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 2'd1, 1'b1, 5'd1, 5'd2, 64'h1234_5678_9ABC_8001);
        run_op(64'h10, 64'h20, 2'd1, 2'd1, 1'b0, 5'd7, 5'd9, 64'hAAAA_AAAA_AAAA_8001);
        run_op(64'h1000, 64'h4, 2'd2, 2'd2, 1'b1, 5'd31, 5'd30, 64'h0123_4567_8000_0000);
        run_op(64'h1000, 64'h4, 2'd2, 2'd2, 1'b0, 5'd31, 5'd30, 64'h0123_4567_8000_0000);
        run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 2'd1, 2'd3, 1'b1, 5'd5, 5'd6, 64'hFEDC_BA98_7654_3210);
        run_op(64'h40, 64'h1, 2'd0, 2'd2, 1'b0, 5'd0, 5'd6, 64'h0);
        run_op(64'h40, 64'h1, 2'd0, 2'd2, 1'b0, 5'd12, 5'd12, 64'h0);
        for (int n = 0; n < 300; n++) begin
            logic [4:0] bi, ti;
            bi = 5'($urandom);
            ti = ($urandom_range(0, 7) == 0) ? bi : 5'($urandom);
            run_op({$urandom, $urandom}, {$urandom, $urandom}, 2'($urandom), 2'($urandom),
                   1'($urandom), bi, ti, {$urandom, $urandom});
        end
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule